// File: doc/BRIEF.md
# Low-Latency DRAM Start-Up Command Sequencer

This block sits on the controller side of a low-latency DRAM and owns the command and address pins from reset until the memory may accept normal traffic. Out of reset it drives only no-operation commands. It waits for the supply-good flag, then keeps the bus idle for a fixed minimum time that is counted in clock cycles. It then issues one unbroken run of mode-register-set commands. The first commands in the run are dummies with the address bus at zero. The last one carries the mode value supplied by the user.

After a short idle tail, a sticky done flag tells the rest of the controller that the device is initialised. The idle time is given in nanoseconds together with the clock frequency in kilohertz, and is rounded up to whole cycles. The number of dummy writes and the tail length are also parameters. Any reset restarts the whole sequence.

Top module: `lldram_pwrup_seq`

## Requirements
- R1: While reset is asserted and directly after it, the command pins {cs_n, we_n, ref_n} show the no-op code 3'b011, the address is all zeros and init_done_o is low.
- R2: As long as power_good_i has never been sampled high, every cycle shows the no-op code and init_done_o stays low, however long that lasts.
- R3: Counting from the rising clock edge that samples power_good_i high, exactly ceil(IDLE_NS * CLK_KHZ / 1e6) cycles carry the no-op code before the first mode-register-set command (code 3'b000).
- R4: The mode-register-set commands form one run of N_DUMMY+1 consecutive cycles with no other command between them.
- R5: In the first N_DUMMY cycles of the run every address bit is zero.
- R6: In the last cycle of the run the address bus equals mode_val_i.
- R7: After the run, exactly POST_WAIT cycles of no-op pass with init_done_o low, and init_done_o is high in the cycle after them.
- R8: Once init_done_o is high it stays high and the command stays no-op until the next reset. Changes of power_good_i after the start has been sampled have no effect on the sequence or on the outputs.
- R9: Asserting reset at any point, including inside the idle wait or inside the command run, returns the outputs to the R1 state. After reset is released, the whole sequence runs again from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_good_i | input | 1 | Supply-stable flag that starts the idle wait |
| mode_val_i | input | ADDR_W | Mode value written by the final set command |
| cmd_o | output | 3 | Command pins {cs_n, we_n, ref_n} |
| addr_o | output | ADDR_W | Address pins |
| init_done_o | output | 1 | High once the memory is initialised |

## Verification
The embedded properties assume that mode_val_i is held steady from the moment power_good_i is sampled until the valid set command has been issued. The output is not registered, so a value that changes in that window would show up directly on the address pins. The properties also assume that reset is the only way to restart the sequence. The bench changes mode_val_i only while reset is held or before power_good_i rises. It toggles power_good_i only after the start has been sampled, which exercises the case where the flag is ignored, and it asserts reset both in the middle of the idle wait and in the middle of the command run.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

   typedef enum logic [2:0] {
      ST_WAIT_PG = 3'd0,
      ST_IDLE    = 3'd1,
      ST_DUMMY   = 3'd2,
      ST_LOAD    = 3'd3,
      ST_POST    = 3'd4,
      ST_DONE    = 3'd5
   } seq_state_t;

   typedef enum logic {
      CMD_NOP = 1'b0,
      CMD_MRS = 1'b1
   } seq_cmd_t;

   localparam int unsigned CMD_PINS = 3;

endpackage

// File: rtl/pwrup_wait_ctr.sv
module pwrup_wait_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] term,
   output logic         last
);

   logic [W-1:0] cnt_q;

   assign last = run && (cnt_q == term - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || last)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + W'(1);
   end

endmodule

// File: rtl/pwrup_cmd_enc.sv
module pwrup_cmd_enc
   import pwrup_seq_pkg::*;
(
   input  seq_cmd_t              cmd,
   output logic [CMD_PINS-1:0]   pins
);

   // {cs_n, we_n, ref_n}, indexed by the command kind
   localparam logic [CMD_PINS-1:0] PIN_TABLE [2] = '{3'b011, 3'b000};

   assign pins = PIN_TABLE[cmd];

endmodule

// File: rtl/lldram_pwrup_seq.sv
module lldram_pwrup_seq
   import pwrup_seq_pkg::*;
#(
   parameter int unsigned CLK_KHZ   = 100000,
   parameter int unsigned IDLE_NS   = 200000,
   parameter int unsigned N_DUMMY   = 2,
   parameter int unsigned POST_WAIT = 8,
   parameter int unsigned ADDR_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              power_good_i,
   input  logic [ADDR_W-1:0] mode_val_i,
   output logic [2:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              init_done_o
);

   localparam longint unsigned IDLE_PROD = longint'(IDLE_NS) * longint'(CLK_KHZ);
   localparam int unsigned IDLE_CYC  = int'((IDLE_PROD + 64'd999999) / 64'd1000000);
   localparam int unsigned MAX_TERM  = (IDLE_CYC > N_DUMMY)
                                     ? ((IDLE_CYC > POST_WAIT) ? IDLE_CYC : POST_WAIT)
                                     : ((N_DUMMY > POST_WAIT) ? N_DUMMY : POST_WAIT);
   localparam int unsigned CNT_W     = $clog2(MAX_TERM + 1);
   localparam logic [2:0]  NOP_PINS  = 3'b011;

   // parameter legality
   generate
      if (N_DUMMY < 2) begin : g_bad_dummy
         $error("N_DUMMY must be at least 2");
      end
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("idle wait must be at least one cycle");
      end
   endgenerate

   // state after the valid set command: skip the tail when it is empty
   localparam seq_state_t AFTER_LOAD = (POST_WAIT == 0) ? ST_DONE : ST_POST;

   seq_state_t       state_q, state_d;
   logic             ctr_run, ctr_last;
   logic [CNT_W-1:0] ctr_term;
   seq_cmd_t         cmd_kind;

   always_comb begin
      ctr_run  = 1'b0;
      ctr_term = '0;
      unique case (state_q)
         ST_IDLE:  begin ctr_run = 1'b1; ctr_term = CNT_W'(IDLE_CYC);  end
         ST_DUMMY: begin ctr_run = 1'b1; ctr_term = CNT_W'(N_DUMMY);   end
         ST_POST:  begin ctr_run = 1'b1; ctr_term = CNT_W'(POST_WAIT); end
         default:  ;
      endcase
   end

   pwrup_wait_ctr #(.W(CNT_W)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctr_run),
      .term  (ctr_term),
      .last  (ctr_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WAIT_PG: if (power_good_i) state_d = ST_IDLE;
         ST_IDLE:    if (ctr_last)     state_d = ST_DUMMY;
         ST_DUMMY:   if (ctr_last)     state_d = ST_LOAD;
         ST_LOAD:                      state_d = AFTER_LOAD;
         ST_POST:    if (ctr_last)     state_d = ST_DONE;
         default:                      state_d = ST_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WAIT_PG;
      else        state_q <= state_d;
   end

   assign cmd_kind    = (state_q == ST_DUMMY || state_q == ST_LOAD) ? CMD_MRS : CMD_NOP;
   assign addr_o      = (state_q == ST_LOAD) ? mode_val_i : '0;
   assign init_done_o = (state_q == ST_DONE);

   pwrup_cmd_enc i_enc (
      .cmd  (cmd_kind),
      .pins (cmd_o)
   );

   // ---------------- checking logic ----------------
   localparam int unsigned RUN_W = $clog2(N_DUMMY + 3);
   localparam int unsigned SEEN_W = $clog2(IDLE_CYC + 2);

   logic              is_mrs;
   logic [RUN_W-1:0]  mrs_run_q;
   logic              started_q;
   logic [SEEN_W-1:0] seen_q;

   assign is_mrs = (cmd_o == 3'b000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mrs_run_q <= '0;
         started_q <= 1'b0;
         seen_q    <= '0;
      end else begin
         mrs_run_q <= is_mrs ? mrs_run_q + RUN_W'(1) : '0;
         if (power_good_i) started_q <= 1'b1;
         if (started_q && seen_q < SEEN_W'(IDLE_CYC)) seen_q <= seen_q + SEEN_W'(1);
      end
   end

   // R2
   wait_pg_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> (cmd_o == NOP_PINS && !init_done_o));

   // R3
   idle_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_mrs) |-> seen_q >= SEEN_W'(IDLE_CYC));

   // R4
   mrs_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_mrs && mrs_run_q != '0) |-> mrs_run_q == RUN_W'(N_DUMMY + 1));

   // R5
   dummy_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && mrs_run_q < RUN_W'(N_DUMMY)) |-> addr_o == '0);

   // R6
   valid_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && mrs_run_q == RUN_W'(N_DUMMY)) |-> addr_o == mode_val_i);

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |=> init_done_o);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |-> cmd_o == NOP_PINS);

endmodule

// File: tb/test_lldram_pwrup_seq.sv
module test_lldram_pwrup_seq;

   localparam int AW       = 18;
   localparam int ND       = 3;
   localparam int EXP_POST = 5;
   localparam int EXP_IDLE = 201;   // ceil(2005 ns * 100 MHz) = ceil(200.5)
   localparam logic [2:0] NOP = 3'b011;
   localparam logic [2:0] MRS = 3'b000;

   localparam int          VEC_N = 4;
   localparam int          VEC_PRE  [VEC_N] = '{0, 3, 17, 1};
   localparam logic [AW-1:0] VEC_MODE [VEC_N] = '{18'h3FFFF, 18'h00001, 18'h2A5C3, 18'h00000};
   localparam bit          VEC_DROP [VEC_N] = '{1'b0, 1'b1, 1'b0, 1'b1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          power_good_i = 1'b0;
   logic [AW-1:0] mode_val_i = '0;
   logic [2:0]    cmd_o;
   logic [AW-1:0] addr_o;
   logic          init_done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lldram_pwrup_seq #(
      .CLK_KHZ(100000), .IDLE_NS(2005), .N_DUMMY(ND),
      .POST_WAIT(EXP_POST), .ADDR_W(AW)
   ) i_lldram_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .power_good_i(power_good_i),
      .mode_val_i(mode_val_i), .cmd_o(cmd_o), .addr_o(addr_o),
      .init_done_o(init_done_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_reset_state(input string req);
      chk(cmd_o == NOP, req, cmd_o, NOP);
      chk(addr_o == '0 && !init_done_o, req, {addr_o, init_done_o}, 0);
   endtask

   // full sequence from a freshly released reset
   task automatic run_seq(input int pre, input logic [AW-1:0] mode, input bit drop);
      int bad = 0;
      int nops = 0;
      int run = 0;
      int post = 0;
      int guard = 0;
      logic [AW-1:0] last_addr = '0;
      power_good_i = 1'b0;
      mode_val_i   = mode;
      for (int i = 0; i < pre; i++) begin
         step();
         if (cmd_o != NOP || init_done_o) bad++;
      end
      chk(bad == 0, "R2", bad, 0);
      power_good_i = 1'b1;
      step();
      if (drop) power_good_i = 1'b0;
      while (cmd_o != MRS && guard < 2000) begin
         if (cmd_o == NOP && !init_done_o) nops++;
         step();
         guard++;
      end
      chk(nops == EXP_IDLE, "R3", nops, EXP_IDLE);
      bad = 0;
      while (cmd_o == MRS && run < 50) begin
         if (run < ND && addr_o != '0) bad++;
         last_addr = addr_o;
         run++;
         if (drop) power_good_i = run[0];
         step();
      end
      chk(run == ND + 1, "R4", run, ND + 1);
      chk(bad == 0, "R5", bad, 0);
      chk(last_addr == mode, "R6", last_addr, mode);
      while (!init_done_o && cmd_o == NOP && post < 100) begin
         post++;
         step();
      end
      chk(post == EXP_POST, "R7", post, EXP_POST);
      chk(init_done_o == 1'b1, "R7", init_done_o, 1);
      bad = 0;
      for (int i = 0; i < 12; i++) begin
         power_good_i = i[1];
         step();
         if (!init_done_o || cmd_o != NOP || addr_o != '0) bad++;
      end
      chk(bad == 0, "R8", bad, 0);
   endtask

   initial begin
      mode_val_i = '0;
      #1;
      chk_reset_state("R1");
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk_reset_state("R1");

      // vector table
      for (int v = 0; v < VEC_N; v++) begin
         rst_n = 1'b0;
         power_good_i = 1'b0;
         mode_val_i = VEC_MODE[v];
         step();
         rst_n = 1'b1;
         run_seq(VEC_PRE[v], VEC_MODE[v], VEC_DROP[v]);
      end

      // R2: long wait without power-good
      begin
         int bad = 0;
         rst_n = 1'b0; power_good_i = 1'b0;
         step();
         rst_n = 1'b1;
         for (int i = 0; i < 400; i++) begin
            step();
            if (cmd_o != NOP || init_done_o) bad++;
         end
         chk(bad == 0, "R2", bad, 0);
      end

      // R9: reset in the middle of the idle wait
      power_good_i = 1'b1;
      mode_val_i = 18'h1B2C4;
      for (int i = 0; i < 60; i++) step();
      rst_n = 1'b0;
      #1;
      chk_reset_state("R9");
      step();
      rst_n = 1'b1;
      run_seq(2, 18'h1B2C4, 1'b0);

      // R9: reset inside the command run
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      power_good_i = 1'b1;
      for (int i = 0; i < EXP_IDLE + 2; i++) step();
      chk(cmd_o == MRS, "R9", cmd_o, MRS);
      rst_n = 1'b0;
      #1;
      chk_reset_state("R9");
      step();
      rst_n = 1'b1;
      run_seq(4, 18'h0F0F0, 1'b1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule